// File: doc/BRIEF.md
# Dual-Port Synchronous SRAM with Cross-Port Forwarding

This block is a single-clock memory with two independent ports, X and Y. Each port has its own address, write data and control inputs. On every rising clock edge each port can write its incoming word to the array, read a word from the array, or forward its incoming word straight to the output of the other port without touching the array. Reads and forwarded words come out one clock after they are requested, through an output register on each port.

A shared pair of chip-select inputs gates the whole cycle. Fixed rules settle collisions when both ports use the same address in one cycle. Each port has an asynchronous output enable, which acts on that port's drive-enable signal. The bidirectional data buses of a real macro are split here into data-in, data-out and drive-enable per port. The memory depth is `2**ADDR_W` words of `DATA_W` bits. A full-size instance uses `ADDR_W = 15` and `DATA_W = 36`.

Top module: `dual_port_pt_ram`

## Requirements
- R1: All inputs except the two output enables are captured on the rising clock edge. A read or forwarded word appears on `dout_*` after the next rising edge, which is one clock after capture.
- R2: A cycle is selected only when `ce1_n` is 0 and `ce2` is 1. A deselected cycle writes nothing, reads nothing and forwards nothing, and both drive-enables are 0 in the following cycle.
- R3: When a port's `wen_*_n` is 0 in a selected cycle, that port's `din_*` is stored at that port's `addr_*`.
- R4: When `pass_x_n` is 0 in a selected cycle, `din_x` appears on `dout_y` one clock later. When `pass_y_n` is 0, `din_y` appears on `dout_x` one clock later. Forwarding may be combined with a write on either port.
- R5: Forwarding into a port takes priority over that port's read.
- R6: A port reads the array only when its `wen_*_n`, `pass_x_n` and `pass_y_n` are all 1. Both ports may read in the same cycle, including from the same address, and each returns the stored word.
- R7: When one port writes and the other port reads the same address in one cycle, the reader returns the word stored before that write.
- R8: When both ports write the same address in one cycle, only `din_y` is stored.
- R9: While `oen_*_n` is 1, that port's `drive_*` is 0 at once, without waiting for a clock edge. `drive_*` returns to its clocked value as soon as `oen_*_n` is 0 again.
- R10: In the cycle after a port neither read nor received a forwarded word, its `drive_*` is 0 and its `dout_*` keeps its previous value.
- R11: After reset, `dout_x` and `dout_y` are 0 and both drive-enables are 0. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| addr_x | input | ADDR_W | Port X address |
| din_x | input | DATA_W | Port X write or forward data |
| wen_x_n | input | 1 | Port X write enable, active low |
| pass_x_n | input | 1 | Forward port X data to port Y, active low |
| oen_x_n | input | 1 | Port X output enable, active low, asynchronous |
| dout_x | output | DATA_W | Port X registered output data |
| drive_x | output | 1 | Port X drive enable for the data bus |
| addr_y | input | ADDR_W | Port Y address |
| din_y | input | DATA_W | Port Y write or forward data |
| wen_y_n | input | 1 | Port Y write enable, active low |
| pass_y_n | input | 1 | Forward port Y data to port X, active low |
| oen_y_n | input | 1 | Port Y output enable, active low, asynchronous |
| dout_y | output | DATA_W | Port Y registered output data |
| drive_y | output | 1 | Port Y drive enable for the data bus |

## Verification
Directed sequences cover the special cases.
- Both ports write one address, which shows whether X or Y is stored.
- One port writes while the other reads that address, which separates read-before-write from write-through.
- A forward is issued while the receiving port reads, which shows which one wins.
- Deselects use each chip-select polarity, which exposes a wrong select decode.

A random stream runs on a 16-word array, so address collisions and mixed command combinations are frequent. It is checked against a bench model that performs all reads before the writes and applies port Y's write last. Toggling an output enable in the middle of a cycle separates the asynchronous gating from the registered drive state.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   // Decoded action of one port for the cycle held in the input registers
   typedef struct packed {
      logic wr;    // store own data in the array
      logic rd;    // load output register from the array
      logic recv;  // load output register from the peer's data
   } port_cmd_t;

   localparam int NUM_PORTS = 2;
   localparam int PORT_X    = 0;
   localparam int PORT_Y    = 1;

endpackage

// File: rtl/dpr_in_reg.sv
module dpr_in_reg #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              wen_n_i,
   input  logic              pass_n_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              wen_n_o,
   output logic              pass_n_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o   <= '0;
         data_o   <= '0;
         wen_n_o  <= 1'b1;
         pass_n_o <= 1'b1;
      end else begin
         addr_o   <= addr_i;
         data_o   <= data_i;
         wen_n_o  <= wen_n_i;
         pass_n_o <= pass_n_i;
      end
   end

endmodule

// File: rtl/dpr_decode.sv
module dpr_decode
   import dpr_pkg::*;
(
   input  logic      sel,
   input  logic      own_wen_n,
   input  logic      own_pass_n,
   input  logic      peer_pass_n,
   output port_cmd_t cmd
);

   always_comb begin
      cmd.wr   = sel & ~own_wen_n;
      cmd.recv = sel & ~peer_pass_n;
      cmd.rd   = sel & own_wen_n & own_pass_n & peer_pass_n;
   end

endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_x,
   input  logic [ADDR_W-1:0] addr_x,
   input  logic [DATA_W-1:0] wdata_x,
   input  logic              we_y,
   input  logic [ADDR_W-1:0] addr_y,
   input  logic [DATA_W-1:0] wdata_y,
   output logic [DATA_W-1:0] rdata_x,
   output logic [DATA_W-1:0] rdata_y
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Reads return the contents held before this edge's writes
   assign rdata_x = mem[addr_x];
   assign rdata_y = mem[addr_y];

   // Port Y is applied last, so it owns a shared address
   always_ff @(posedge clk) begin
      if (we_x) mem[addr_x] <= wdata_x;
      if (we_y) mem[addr_y] <= wdata_y;
   end

   // R8
   y_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_x && we_y && addr_x == addr_y) |=> mem[$past(addr_y)] == $past(wdata_y));

   // R3
   x_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_x && !(we_y && addr_x == addr_y)) |=> mem[$past(addr_x)] == $past(wdata_x));

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage
   import dpr_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_cmd_t         cmd,
   input  logic [DATA_W-1:0] arr_data,
   input  logic [DATA_W-1:0] peer_data,
   input  logic              oen_n,
   output logic [DATA_W-1:0] dout,
   output logic              valid,
   output logic              drive
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= cmd.recv | cmd.rd;
         if (cmd.recv)    dout <= peer_data;
         else if (cmd.rd) dout <= arr_data;
      end
   end

   assign drive = valid & ~oen_n;

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.recv && !cmd.rd) |=> (!valid && $stable(dout)));

   // R6
   array_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.rd && !cmd.recv) |=> (valid && dout == $past(arr_data)));

endmodule

// File: rtl/dual_port_pt_ram.sv
module dual_port_pt_ram
   import dpr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic [ADDR_W-1:0] addr_x,
   input  logic [DATA_W-1:0] din_x,
   input  logic              wen_x_n,
   input  logic              pass_x_n,
   input  logic              oen_x_n,
   output logic [DATA_W-1:0] dout_x,
   output logic              drive_x,
   input  logic [ADDR_W-1:0] addr_y,
   input  logic [DATA_W-1:0] din_y,
   input  logic              wen_y_n,
   input  logic              pass_y_n,
   input  logic              oen_y_n,
   output logic [DATA_W-1:0] dout_y,
   output logic              drive_y
);

   localparam int NP = NUM_PORTS;

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr_w
      $error("dual_port_pt_ram: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dual_port_pt_ram: DATA_W must be positive");
   end

   logic [NP-1:0][ADDR_W-1:0] addr_in, addr_q;
   logic [NP-1:0][DATA_W-1:0] din_in, din_q, rdata, dout_v;
   logic [NP-1:0]             wen_in, pass_in, oen_in;
   logic [NP-1:0]             wen_q, pass_q, valid, drv;
   port_cmd_t [NP-1:0]        cmd;
   logic                      sel_q;

   assign addr_in = {addr_y, addr_x};
   assign din_in  = {din_y, din_x};
   assign wen_in  = {wen_y_n, wen_x_n};
   assign pass_in = {pass_y_n, pass_x_n};
   assign oen_in  = {oen_y_n, oen_x_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= ~ce1_n & ce2;
   end

   for (genvar p = 0; p < NP; p++) begin : g_port
      dpr_in_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
         .clk      (clk),
         .rst_n    (rst_n),
         .addr_i   (addr_in[p]),
         .data_i   (din_in[p]),
         .wen_n_i  (wen_in[p]),
         .pass_n_i (pass_in[p]),
         .addr_o   (addr_q[p]),
         .data_o   (din_q[p]),
         .wen_n_o  (wen_q[p]),
         .pass_n_o (pass_q[p])
      );

      dpr_decode u_dec (
         .sel         (sel_q),
         .own_wen_n   (wen_q[p]),
         .own_pass_n  (pass_q[p]),
         .peer_pass_n (pass_q[NP-1-p]),
         .cmd         (cmd[p])
      );

      dpr_out_stage #(.DATA_W(DATA_W)) u_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd       (cmd[p]),
         .arr_data  (rdata[p]),
         .peer_data (din_q[NP-1-p]),
         .oen_n     (oen_in[p]),
         .dout      (dout_v[p]),
         .valid     (valid[p]),
         .drive     (drv[p])
      );
   end

   dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_x    (cmd[PORT_X].wr),
      .addr_x  (addr_q[PORT_X]),
      .wdata_x (din_q[PORT_X]),
      .we_y    (cmd[PORT_Y].wr),
      .addr_y  (addr_q[PORT_Y]),
      .wdata_y (din_q[PORT_Y]),
      .rdata_x (rdata[PORT_X]),
      .rdata_y (rdata[PORT_Y])
   );

   assign dout_x  = dout_v[PORT_X];
   assign dout_y  = dout_v[PORT_Y];
   assign drive_x = drv[PORT_X];
   assign drive_y = drv[PORT_Y];

   // R2
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |=> (!valid[PORT_X] && !valid[PORT_Y]));

   // R5
   fwd_to_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd[PORT_X].recv |=> (valid[PORT_X] && dout_x == $past(din_q[PORT_Y])));

   // R4
   fwd_to_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd[PORT_Y].recv |=> (valid[PORT_Y] && dout_y == $past(din_q[PORT_X])));

   // R7
   read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd[PORT_X].rd && cmd[PORT_Y].wr && addr_q[PORT_X] == addr_q[PORT_Y])
      |=> dout_x == $past(rdata[PORT_X]));

endmodule

// File: tb/test_dual_port_pt_ram.sv
module test_dual_port_pt_ram;

   localparam int AW = 4;
   localparam int DW = 36;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce1_n = 1'b1, ce2 = 1'b0;
   logic [AW-1:0] addr_x = '0, addr_y = '0;
   logic [DW-1:0] din_x = '0, din_y = '0;
   logic wen_x_n = 1'b1, wen_y_n = 1'b1, pass_x_n = 1'b1, pass_y_n = 1'b1;
   logic oen_x_n = 1'b0, oen_y_n = 1'b0;
   logic [DW-1:0] dout_x, dout_y;
   logic drive_x, drive_y;

   dual_port_pt_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dual_port_pt_ram (
      .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2),
      .addr_x(addr_x), .din_x(din_x), .wen_x_n(wen_x_n), .pass_x_n(pass_x_n),
      .oen_x_n(oen_x_n), .dout_x(dout_x), .drive_x(drive_x),
      .addr_y(addr_y), .din_y(din_y), .wen_y_n(wen_y_n), .pass_y_n(pass_y_n),
      .oen_y_n(oen_y_n), .dout_y(dout_y), .drive_y(drive_y)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [DW-1:0] mdl [DEPTH];
   logic [DW-1:0] exp_dx = '0, exp_dy = '0;
   logic exp_vx = 1'b0, exp_vy = 1'b0;
   string prev_tag = "R11";

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return {a[3:0], 32'hC35A_0000 + 32'(a * 32'h0101_0013)};
   endfunction

   // One cycle: drive a command, then check the outputs produced by the
   // previous command, then advance the model with this command.
   task automatic step(input string tag, input logic c1n, input logic c2,
                       input logic [AW-1:0] ax, input logic [DW-1:0] dx,
                       input logic wxn, input logic pxn,
                       input logic [AW-1:0] ay, input logic [DW-1:0] dy,
                       input logic wyn, input logic pyn);
      logic sel, rx, ry, cx, cy;
      ce1_n = c1n; ce2 = c2;
      addr_x = ax; din_x = dx; wen_x_n = wxn; pass_x_n = pxn;
      addr_y = ay; din_y = dy; wen_y_n = wyn; pass_y_n = pyn;
      @(posedge clk);
      @(negedge clk);
      chk(dout_x == exp_dx, prev_tag, "R1 dout_x", dout_x, exp_dx);
      chk(drive_x == (exp_vx & ~oen_x_n), prev_tag, "R10 drive_x",
          DW'(drive_x), DW'(exp_vx & ~oen_x_n));
      chk(dout_y == exp_dy, prev_tag, "R1 dout_y", dout_y, exp_dy);
      chk(drive_y == (exp_vy & ~oen_y_n), prev_tag, "R10 drive_y",
          DW'(drive_y), DW'(exp_vy & ~oen_y_n));
      sel = !c1n && c2;
      cx  = sel && !pyn;
      cy  = sel && !pxn;
      rx  = sel && wxn && pxn && pyn;
      ry  = sel && wyn && pxn && pyn;
      if (cx)      exp_dx = dy;
      else if (rx) exp_dx = mdl[ax];
      if (cy)      exp_dy = dx;
      else if (ry) exp_dy = mdl[ay];
      exp_vx = cx | rx;
      exp_vy = cy | ry;
      if (sel && !wxn) mdl[ax] = dx;
      if (sel && !wyn) mdl[ay] = dy;
      prev_tag = tag;
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b0, 1'b1, '0, '0, 1'b1, 1'b1, '0, '0, 1'b1, 1'b0 | 1'b1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] r1, r2;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(dout_x == '0, "R11", "dout_x after reset", dout_x, '0);
      chk(dout_y == '0, "R11", "dout_y after reset", dout_y, '0);
      chk(!drive_x && !drive_y, "R11", "drives after reset",
          DW'({drive_x, drive_y}), '0);

      // R3 fill the array, alternating ports
      for (int a = 0; a < DEPTH; a++) begin
         if (a % 2 == 0)
            step("R3", 1'b0, 1'b1, AW'(a), pat(a), 1'b0, 1'b1, '0, '0, 1'b1, 1'b1);
         else
            step("R3", 1'b0, 1'b1, '0, '0, 1'b1, 1'b1, AW'(a), pat(a), 1'b0, 1'b1);
      end

      // R6 both ports read the same address
      step("R6", 1'b0, 1'b1, 4'd3, '0, 1'b1, 1'b1, 4'd3, '0, 1'b1, 1'b1);
      idle("R10");
      chk(dout_x == pat(3) && dout_y == pat(3), "R6", "same-address read",
          dout_x, pat(3));

      // R9 output enable gates the drive without a clock
      step("R6", 1'b0, 1'b1, 4'd4, '0, 1'b1, 1'b1, 4'd5, '0, 1'b1, 1'b1);
      ce1_n = 1'b1;
      @(posedge clk);
      #1;
      oen_x_n = 1'b1;
      #1;
      chk(drive_x == 1'b0, "R9", "drive_x with oen high", DW'(drive_x), '0);
      chk(drive_y == 1'b1, "R9", "drive_y unaffected", DW'(drive_y), DW'(1));
      oen_x_n = 1'b0;
      #1;
      chk(drive_x == 1'b1, "R9", "drive_x restored", DW'(drive_x), DW'(1));
      chk(dout_x == pat(4), "R1", "read data one clock later", dout_x, pat(4));
      @(negedge clk);
      exp_dx = pat(4); exp_dy = pat(5); exp_vx = 1'b0; exp_vy = 1'b0;
      prev_tag = "R2";

      // R8 both ports write the same address
      step("R8", 1'b0, 1'b1, 4'd7, 36'h1_1111_1111, 1'b0, 1'b1,
           4'd7, 36'h2_2222_2222, 1'b0, 1'b1);
      step("R8", 1'b0, 1'b1, 4'd7, '0, 1'b1, 1'b1, '0, '0, 1'b1, 1'b1);
      idle("R10");
      chk(dout_x == 36'h2_2222_2222, "R8", "Y data stored", dout_x, 36'h2_2222_2222);

      // R7 X writes while Y reads the same address
      step("R7", 1'b0, 1'b1, 4'd6, 36'h9_8765_4321, 1'b0, 1'b1,
           4'd6, '0, 1'b1, 1'b1);
      idle("R10");
      chk(dout_y == pat(6), "R7", "reader sees old word", dout_y, pat(6));

      // R5 forward into X beats X's read; R4 forward combined with writes
      step("R5", 1'b0, 1'b1, 4'd2, '0, 1'b1, 1'b1,
           4'd9, 36'h5_0505_0505, 1'b1, 1'b0);
      idle("R10");
      chk(dout_x == 36'h5_0505_0505, "R5", "forward wins over read",
          dout_x, 36'h5_0505_0505);
      step("R4", 1'b0, 1'b1, 4'd10, 36'h6_ABCD_0001, 1'b0, 1'b0,
           4'd11, 36'h7_ABCD_0002, 1'b0, 1'b0);
      idle("R10");
      chk(dout_y == 36'h6_ABCD_0001 && dout_x == 36'h7_ABCD_0002, "R4",
          "cross forward with writes", dout_y, 36'h6_ABCD_0001);

      // R2 deselect by each chip-select polarity blocks a write and reads
      step("R2", 1'b1, 1'b1, 4'd12, 36'hF_0000_000F, 1'b0, 1'b1,
           4'd12, '0, 1'b1, 1'b1);
      step("R2", 1'b0, 1'b0, 4'd13, '0, 1'b1, 1'b1,
           4'd13, 36'hE_0000_000E, 1'b0, 1'b0);
      chk(!drive_x && !drive_y, "R2", "no drive after deselect",
          DW'({drive_x, drive_y}), '0);
      step("R2", 1'b0, 1'b1, 4'd12, '0, 1'b1, 1'b1, 4'd13, '0, 1'b1, 1'b1);
      idle("R10");
      chk(dout_x == pat(12) && dout_y == pat(13), "R2", "array unchanged",
          dout_x, pat(12));

      // Random mix on a small array: collisions are frequent
      for (int i = 0; i < 600; i++) begin
         r1 = {$urandom(), $urandom()};
         r2 = {$urandom(), $urandom()};
         step("R3/R4/R5/R6/R7/R8",
              ($urandom % 10) == 0, ($urandom % 10) != 0,
              AW'($urandom % 4), r1[DW-1:0], ($urandom % 3) != 0, ($urandom % 4) != 0,
              AW'($urandom % 4), r2[DW-1:0], ($urandom % 3) != 0, ($urandom % 4) != 0);
      end
      idle("R10");
      idle("R10");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule